// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block takes a clock generator's output groups into and out of a low-power state. An asynchronous active-low request input is passed through a two-stage synchronizer. When it asserts, every gated clock group is parked low once its current cycle has finished. Once every group reports that it is parked, the block drops its oscillator and PLL enables. When the request is released, the oscillator enable comes back first. The PLL enable follows on the first reference tick. The outputs are released only after a settling interval, counted in reference-clock periods.

Three gated groups are modelled from the control clock: a fast group, a bus group and a free-running copy of the bus group. The two ordinary groups each have an active-low stop input. The free-running copy has none. The reference-rate output is not part of the cycle-aligned parking. It runs whenever the oscillator enable is high and is forced low when the oscillator is off. The oscillator and PLL exist only as enables and timers. A gate can switch on only at the start of a high half-period and switches off only after a falling half, so no pulse is ever shortened or stretched.

Top module: `clkgen_pd_seq`

## Requirements
- R1: While reset is high, all three group clocks and the reference output are low, and both the oscillator and PLL enables are high.
- R2: In normal operation the fast group has a period of 2*FAST_HALF control cycles. The bus group and its free-running copy each have a period of 2*BUS_HALF. The reference output has a period of 2*REF_HALF.
- R3: Every high pulse on a group clock lasts exactly its half-period. Every low gap lasts at least its half-period. This holds across stops, power-down entry, aborted wake-ups and exit.
- R4: After the request input falls, the fast group's last high cycle ends within three fast periods (6*FAST_HALF control cycles). All group clocks then stay low for the rest of the power-down.
- R5: The oscillator and PLL enables drop only after every group clock is parked low. The reference output is low while the oscillator enable is low.
- R6: While a power-down is in progress (parking, oscillator off, wake-up or settling), the stop inputs have no effect, and no group clock rises even if both stop inputs are released.
- R7: On release, the oscillator enable rises before the PLL enable. The groups restart no earlier than SETTLE_TICKS reference periods after the release, and no more than 14 control cycles after that point.
- R8: If the request input asserts again during wake-up or settling, the block returns to the oscillator-off state. No group clock pulses in between.
- R9: Driving stop_n_i[0] low stops the fast group low at the end of its current cycle while the other groups keep running. Releasing it restarts the fast group with a full pulse.
- R10: Driving stop_n_i[1] low stops the bus group, and the free-running bus copy keeps its period.
- R11: The reference output keeps running while a group is stopped and while the groups are being parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; every generated clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| stop_n_i | input | 2 | Active-low stop per group: bit 0 fast, bit 1 bus |
| fast_clk_o | output | 1 | Gated fast group clock |
| bus_clk_o | output | 1 | Gated bus group clock |
| bus_free_clk_o | output | 1 | Bus-rate clock that ignores stop inputs |
| ref_clk_o | output | 1 | Reference-rate clock, runs while the oscillator is enabled |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
The bench builds the block with FAST_HALF=1, BUS_HALF=3, REF_HALF=2 and SETTLE_TICKS=8. With these values a full wake-up takes only about forty control cycles, so the exact settle window can be bounded from both sides. The aborted-settle case can be hit at a known point, and repeated entry and exit fit in a short run. A one-cycle fast half-period puts the fast group's park point on every other edge, which makes the three-period entry bound tight. Because the bus and fast groups have unequal ratios, the free-running copy can be told apart from the stoppable bus group.

// File: rtl/clkgen_pd_pkg.sv
package clkgen_pd_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PARK,
    ST_OSC_OFF,
    ST_WAKE,
    ST_SETTLE
  } pd_state_e;

  localparam int unsigned N_GROUPS = 3;
  localparam int unsigned N_STOPS  = 2;

endpackage

// File: rtl/clkgen_pd_sync.sv
module clkgen_pd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/clkgen_pd_gate.sv
// Divides the control clock by 2*HALF and gates the result so that it can
// only start at a rising half and only stop after a falling half.
module clkgen_pd_gate #(
  parameter int unsigned HALF = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic clk_o,
  output logic parked_o
);

  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          run_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      if (!phase_q) begin
        // start of a cycle: decide whether this cycle is driven
        run_q <= en_i;
        out_q <= en_i;
      end else begin
        out_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o    = out_q;
  assign parked_o = ~run_q;

endmodule

// File: rtl/clkgen_pd_refdiv.sv
// Reference-rate clock; runs only while the oscillator enable is high.
module clkgen_pd_refdiv #(
  parameter int unsigned REF_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en_i,
  output logic ref_o,
  output logic tick_o
);

  localparam int unsigned CW = (REF_HALF > 1) ? $clog2(REF_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ref_q;

  always_ff @(posedge clk) begin
    if (rst || !osc_en_i) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ref_q <= ~ref_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ref_o  = ref_q;
  assign tick_o = osc_en_i & ~ref_q & (cnt_q == LAST);

endmodule

// File: rtl/clkgen_pd_fsm.sv
module clkgen_pd_fsm
  import clkgen_pd_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req_i,
  input  logic all_parked_i,
  input  logic ref_tick_i,
  output logic hold_o,
  output logic osc_en_o,
  output logic pll_en_o
);

  localparam int unsigned SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_TICKS - 1);

  pd_state_e     st_q, st_nxt;
  logic [SW-1:0] cnt_q, cnt_nxt;
  logic          hold_q, osc_q, pll_q;

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    case (st_q)
      ST_RUN:     if (pd_req_i) st_nxt = ST_PARK;
      ST_PARK:    if (all_parked_i) st_nxt = ST_OSC_OFF;
      ST_OSC_OFF: if (!pd_req_i) st_nxt = ST_WAKE;
      ST_WAKE: begin
        if (pd_req_i) begin
          st_nxt = ST_OSC_OFF;
        end else if (ref_tick_i) begin
          st_nxt  = ST_SETTLE;
          cnt_nxt = '0;
        end
      end
      ST_SETTLE: begin
        if (pd_req_i) begin
          st_nxt = ST_OSC_OFF;
        end else if (ref_tick_i) begin
          if (cnt_q == SETTLE_LAST) st_nxt = ST_RUN;
          else cnt_nxt = cnt_q + 1'b1;
        end
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      osc_q  <= 1'b1;
      pll_q  <= 1'b1;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      hold_q <= (st_nxt != ST_RUN);
      osc_q  <= (st_nxt != ST_OSC_OFF);
      pll_q  <= (st_nxt == ST_RUN) || (st_nxt == ST_PARK) || (st_nxt == ST_SETTLE);
    end
  end

  assign hold_o   = hold_q;
  assign osc_en_o = osc_q;
  assign pll_en_o = pll_q;

endmodule

// File: rtl/clkgen_pd_seq.sv
module clkgen_pd_seq
  import clkgen_pd_pkg::*;
#(
  parameter int unsigned FAST_HALF    = 1,
  parameter int unsigned BUS_HALF     = 3,
  parameter int unsigned REF_HALF     = 2,
  parameter int unsigned SETTLE_TICKS = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_n_i,
  input  logic [1:0] stop_n_i,
  output logic       fast_clk_o,
  output logic       bus_clk_o,
  output logic       bus_free_clk_o,
  output logic       ref_clk_o,
  output logic       osc_en_o,
  output logic       pll_en_o
);

  logic                pd_n_s;
  logic [N_STOPS-1:0]  stop_n_s;
  logic [N_GROUPS-1:0] grp_en;
  logic [N_GROUPS-1:0] grp_clk;
  logic [N_GROUPS-1:0] grp_parked;
  logic                outs_hold;
  logic                ref_tick;
  logic                osc_en;

  clkgen_pd_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst(rst), .d_i(pd_n_i), .q_o(pd_n_s)
  );

  clkgen_pd_sync #(.W(N_STOPS), .RST_VAL({N_STOPS{1'b1}})) u_stop_sync (
    .clk(clk), .rst(rst), .d_i(stop_n_i), .q_o(stop_n_s)
  );

  clkgen_pd_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
    .clk(clk),
    .rst(rst),
    .pd_req_i(~pd_n_s),
    .all_parked_i(&grp_parked),
    .ref_tick_i(ref_tick),
    .hold_o(outs_hold),
    .osc_en_o(osc_en),
    .pll_en_o(pll_en_o)
  );

  clkgen_pd_refdiv #(.REF_HALF(REF_HALF)) u_ref (
    .clk(clk), .rst(rst), .osc_en_i(osc_en), .ref_o(ref_clk_o), .tick_o(ref_tick)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam int unsigned H = (g == 0) ? FAST_HALF : BUS_HALF;
    if (g < N_STOPS) begin : g_stoppable
      assign grp_en[g] = ~outs_hold & stop_n_s[g];
    end else begin : g_free
      assign grp_en[g] = ~outs_hold;
    end
    clkgen_pd_gate #(.HALF(H)) u_gate (
      .clk(clk), .rst(rst), .en_i(grp_en[g]),
      .clk_o(grp_clk[g]), .parked_o(grp_parked[g])
    );
  end

  assign fast_clk_o     = grp_clk[0];
  assign bus_clk_o      = grp_clk[1];
  assign bus_free_clk_o = grp_clk[2];
  assign osc_en_o       = osc_en;

endmodule

// File: rtl/clkgen_pd_chk.sv
module clkgen_pd_chk #(
  parameter int unsigned FAST_HALF = 1,
  parameter int unsigned BUS_HALF  = 3
) (
  input logic clk,
  input logic rst,
  input logic fast_clk_o,
  input logic bus_clk_o,
  input logic bus_free_clk_o,
  input logic ref_clk_o,
  input logic osc_en_o,
  input logic pll_en_o,
  input logic hold
);

  logic [2:0] clks;
  assign clks = {bus_free_clk_o, bus_clk_o, fast_clk_o};

  for (genvar g = 0; g < 3; g++) begin : g_chk
    localparam int unsigned H = (g == 0) ? FAST_HALF : BUS_HALF;
    logic [15:0] hi_cnt;
    always_ff @(posedge clk) begin
      if (rst) hi_cnt <= '0;
      else     hi_cnt <= clks[g] ? hi_cnt + 16'd1 : 16'd0;
    end

    // R3: every high pulse lasts exactly its half-period
    a_r3_hi_width: assert property (@(posedge clk) disable iff (rst)
      $fell(clks[g]) |-> hi_cnt == 16'(H));

    // R6 / R8: no group starts a pulse while the outputs are held
    a_r6_no_rise_in_hold: assert property (@(posedge clk) disable iff (rst)
      $rose(clks[g]) |-> !$past(hold));
  end

  a_r5_parked_while_osc_off: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |-> (clks == 3'b000));

  a_r7_pll_needs_osc: assert property (@(posedge clk) disable iff (rst)
    pll_en_o |-> osc_en_o);

  a_r5_ref_low_osc_off: assert property (@(posedge clk) disable iff (rst)
    (!osc_en_o && !$past(osc_en_o)) |-> !ref_clk_o);

endmodule

bind clkgen_pd_seq clkgen_pd_chk #(.FAST_HALF(FAST_HALF), .BUS_HALF(BUS_HALF)) chk_i (
  .clk(clk),
  .rst(rst),
  .fast_clk_o(fast_clk_o),
  .bus_clk_o(bus_clk_o),
  .bus_free_clk_o(bus_free_clk_o),
  .ref_clk_o(ref_clk_o),
  .osc_en_o(osc_en_o),
  .pll_en_o(pll_en_o),
  .hold(outs_hold)
);

// File: tb/clkgen_pd_seq_tb_top.sv
`timescale 1ns/1ps
module clkgen_pd_seq_tb_top;

  localparam int unsigned FAST_HALF = 1;
  localparam int unsigned BUS_HALF  = 3;
  localparam int unsigned REF_HALF  = 2;
  localparam int unsigned SETTLE    = 8;
  localparam int WAKE_LO = SETTLE * 2 * REF_HALF;
  localparam int WAKE_HI = WAKE_LO + 14;

  logic clk = 1'b0;
  logic rst;
  logic pd_n;
  logic [1:0] stop_n;
  logic fast_c, bus_c, free_c, refc, osc_en, pll_en;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkgen_pd_seq #(
    .FAST_HALF(FAST_HALF), .BUS_HALF(BUS_HALF),
    .REF_HALF(REF_HALF), .SETTLE_TICKS(SETTLE)
  ) dut_i (
    .clk(clk), .rst(rst), .pd_n_i(pd_n), .stop_n_i(stop_n),
    .fast_clk_o(fast_c), .bus_clk_o(bus_c), .bus_free_clk_o(free_c),
    .ref_clk_o(refc), .osc_en_o(osc_en), .pll_en_o(pll_en)
  );

  logic [2:0] cur;
  assign cur = {free_c, bus_c, fast_c};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int half_of(input int g);
    return (g == 0) ? FAST_HALF : BUS_HALF;
  endfunction

  // R3 pulse monitor
  int hi_len [3];
  int lo_len [3];
  bit prv [3];
  always @(negedge clk) begin
    if (rst) begin
      for (int g = 0; g < 3; g++) begin
        hi_len[g] = 0; lo_len[g] = 1000; prv[g] = 1'b0;
      end
    end else begin
      for (int g = 0; g < 3; g++) begin
        if (cur[g] && !prv[g]) begin
          if (lo_len[g] < half_of(g)) pulse_err++;
          hi_len[g] = 1;
        end else if (cur[g]) begin
          hi_len[g]++;
        end else if (prv[g]) begin
          if (hi_len[g] != half_of(g)) pulse_err++;
          lo_len[g] = 1;
        end else begin
          lo_len[g]++;
        end
        prv[g] = cur[g];
      end
    end
  end

  task automatic count_rises(input int n, output int rf, output int rb,
                             output int rfr, output int rr);
    logic [3:0] pv, nv;
    rf = 0; rb = 0; rfr = 0; rr = 0;
    pv = {refc, cur};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nv = {refc, cur};
      if (nv[0] && !pv[0]) rf++;
      if (nv[1] && !pv[1]) rb++;
      if (nv[2] && !pv[2]) rfr++;
      if (nv[3] && !pv[3]) rr++;
      pv = nv;
    end
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  task automatic t_reset();
    rst = 1'b1; pd_n = 1'b1; stop_n = 2'b11;
    repeat (5) @(negedge clk);
    chk({fast_c, bus_c, free_c, refc} == 4'b0, "R1", "clocks low in reset", {fast_c, bus_c, free_c, refc}, 0);
    chk(osc_en && pll_en, "R1", "enables high in reset", {osc_en, pll_en}, 3);
    rst = 1'b0;
  endtask

  task automatic t_run(input string tag);
    int rf, rb, rfr, rr;
    repeat (10) @(negedge clk);
    count_rises(120, rf, rb, rfr, rr);
    chk(near(rf, 120 / (2 * FAST_HALF)), "R2", {tag, " fast rises"}, rf, 120 / (2 * FAST_HALF));
    chk(near(rb, 120 / (2 * BUS_HALF)), "R2", {tag, " bus rises"}, rb, 120 / (2 * BUS_HALF));
    chk(near(rfr, 120 / (2 * BUS_HALF)), "R2", {tag, " free bus rises"}, rfr, 120 / (2 * BUS_HALF));
    chk(near(rr, 120 / (2 * REF_HALF)), "R2", {tag, " ref rises"}, rr, 120 / (2 * REF_HALF));
  endtask

  task automatic t_stop_fast();
    int rf, rb, rfr, rr;
    stop_n[0] = 1'b0;
    repeat (8) @(negedge clk);
    count_rises(24, rf, rb, rfr, rr);
    chk(rf == 0, "R9", "fast stopped", rf, 0);
    chk(near(rb, 24 / (2 * BUS_HALF)), "R9", "bus runs during fast stop", rb, 24 / (2 * BUS_HALF));
    chk(near(rr, 24 / (2 * REF_HALF)), "R11", "ref runs during fast stop", rr, 24 / (2 * REF_HALF));
    stop_n[0] = 1'b1;
    repeat (6) @(negedge clk);
    count_rises(24, rf, rb, rfr, rr);
    chk(near(rf, 24 / (2 * FAST_HALF)), "R9", "fast restarted", rf, 24 / (2 * FAST_HALF));
  endtask

  task automatic t_stop_bus();
    int rf, rb, rfr, rr;
    stop_n[1] = 1'b0;
    repeat (12) @(negedge clk);
    count_rises(30, rf, rb, rfr, rr);
    chk(rb == 0, "R10", "bus stopped", rb, 0);
    chk(near(rfr, 30 / (2 * BUS_HALF)), "R10", "free bus keeps period", rfr, 30 / (2 * BUS_HALF));
    stop_n[1] = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_pd_entry();
    int last_hi = 0;
    int ref_during_park = 0;
    pd_n = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (fast_c) last_hi = k;
      if (refc && osc_en) ref_during_park++;
    end
    chk(last_hi < 6 * FAST_HALF, "R4", "fast last high cycle after request", last_hi, 6 * FAST_HALF - 1);
    chk(!osc_en && !pll_en, "R5", "enables off after parking", {osc_en, pll_en}, 0);
    chk(ref_during_park > 0, "R11", "ref ran while parking", ref_during_park, 1);
    chk(!refc, "R5", "ref low with oscillator off", refc, 0);
  endtask

  task automatic t_stop_ignored();
    int rf, rb, rfr, rr;
    stop_n = 2'b00;
    repeat (6) @(negedge clk);
    stop_n = 2'b11;
    count_rises(30, rf, rb, rfr, rr);
    chk(rf + rb + rfr + rr == 0, "R6", "no pulses after stop toggles in power-down", rf + rb + rfr + rr, 0);
    chk(!osc_en, "R6", "oscillator stays off", osc_en, 0);
  endtask

  task automatic t_wake();
    int lat = -1;
    int osc_at = -1;
    bit pll_first = 1'b0;
    pd_n = 1'b1;
    for (int k = 1; k <= WAKE_HI + 10; k++) begin
      @(negedge clk);
      if (osc_en && osc_at < 0) begin
        osc_at = k;
        pll_first = pll_en;
      end
      if (fast_c && lat < 0) lat = k;
    end
    chk(osc_at > 0 && !pll_first, "R7", "oscillator on before PLL", pll_first, 0);
    chk(lat >= WAKE_LO && lat <= WAKE_HI, "R7", "wake latency", lat, WAKE_LO);
    chk(osc_en && pll_en, "R7", "enables on after wake", {osc_en, pll_en}, 3);
  endtask

  task automatic t_settle_abort();
    int rf, rb, rfr, rr;
    int tf, tb, tfr, tr;
    pd_n = 1'b1;
    count_rises(20, rf, rb, rfr, rr);
    chk(pll_en && osc_en, "R8", "in settle before abort", {osc_en, pll_en}, 3);
    pd_n = 1'b0;
    count_rises(20, tf, tb, tfr, tr);
    chk(rf + rb + rfr + tf + tb + tfr == 0, "R8", "no pulse during aborted wake", rf + rb + rfr + tf + tb + tfr, 0);
    chk(!osc_en && !pll_en, "R8", "back to oscillator off", {osc_en, pll_en}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run("initial");
    t_stop_fast();
    t_stop_bus();
    t_pd_entry();
    t_stop_ignored();
    t_wake();
    t_run("after wake");
    t_pd_entry();
    t_settle_abort();
    t_wake();
    t_run("after abort");
    chk(pulse_err == 0, "R3", "pulse width violations", pulse_err, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule